// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 12-bit charge-redistribution successive-approximation converter. It runs on the serial clock. While chip select is high it holds the analog front end in acquisition through a sample-enable output. Once chip select falls, it runs a binary search over the reference. On each clock it drives a trial code to the capacitive DAC and reads one comparator decision back.

A conversion frame overlaps two tasks. While the current sample is being resolved bit by bit, the code finished in the previous frame is shifted out on the serial data line, most significant bit first, launched on falling clock edges. A frame that ends early, or that started after too short an acquisition, leaves the stored result untouched. The next frame then sends the older code again. An elaboration parameter chooses the output format. It can be plain binary, or two's complement with zero differential input mapped to code zero.

Top module: `sar_sequencer`

## Requirements
- R1: During and directly after reset, sample_en is 1, dac_code is 0 and sdo is 0, and the stored result is 0.
- R2: sample_en goes to 1 at the first rising edge that samples cs_n high. It goes to 0 at the first rising edge that samples cs_n low.
- R3: If cs_n was sampled high on at least MIN_ACQ (default 2) consecutive rising edges, the first rising edge that samples it low sets dac_code to the mid-scale trial value, with only the most significant bit set (0x800 for 12 bits).
- R4: On each of the following N rising edges with cs_n low, the bit under test is cleared when cmp_below is 1 (input below the DAC level) and kept when it is 0. The next lower bit is then set. After the N-th decision, dac_code holds the final code until cs_n is sampled high.
- R5: The result of a completed conversion is sent in the next frame. The most significant bit appears on sdo at the first falling edge after the rising edge that starts the frame. Each following falling edge presents the next lower bit. After N bits, sdo stays 0.
- R6: sdo is 0 whenever cs_n is high, and it is 0 between the fall of cs_n and the first falling edge of the frame.
- R7: With SIGNED_OUT=0 the word sent is the raw search code. With SIGNED_OUT=1 its most significant bit is inverted, so a mid-scale input (raw 0x800) is sent as 0x000.
- R8: If cs_n is sampled high before the N-th decision, the conversion is dropped and the stored result is unchanged. The next frame sends the previous result again.
- R9: If cs_n was high on fewer than MIN_ACQ rising edges, the following frame makes no decisions. dac_code stays 0 and the stored result is kept, but the stored result is still transmitted.
- R10: dac_code is 0 after every rising edge that samples cs_n high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; decisions on rising edges, data launched on falling edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high = acquisition |
| cmp_below | input | 1 | Comparator: 1 when the held input is below the DAC level |
| sample_en | output | 1 | Sample/hold enable for the front end |
| dac_code | output | N | Trial code for the capacitive DAC |
| sdo | output | 1 | Serial result, MSB first |

## Verification
The binary search for the current sample and the shift-out of the previous sample share every clock of a frame. The hazard is the rising edge that makes the last decision and updates the stored result. That result must not leak into the word already on the wire. The bench provokes this with back-to-back frames whose analog inputs differ in every bit position. It drives an unsigned and a signed instance side by side. It compares dac_code, sample_en and sdo against a behavioural model on every clock, and it reassembles each transmitted word to confirm it equals the code decided one frame earlier. Early chip-select release and short acquisition are mixed into the same sequence, so the retained result is judged through the bits that come out next.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

   // Frame phase of the sequencer
   typedef enum logic [1:0] {
      SQ_ACQ   = 2'd0,   // input tracked, waiting for chip select to fall
      SQ_TRIAL = 2'd1,   // binary search in progress
      SQ_HOLD  = 2'd2    // search finished or skipped, waiting for chip select to rise
   } sar_phase_t;

endpackage

// File: rtl/sar_ctrl.sv
`timescale 1ns/1ps
module sar_ctrl #(
   parameter int N       = 12,
   parameter int MIN_ACQ = 2,
   localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
   localparam int ACQ_W  = $clog2(MIN_ACQ + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   output sar_pkg::sar_phase_t phase,
   output logic [IDX_W-1:0]    bit_idx,
   output logic                frame_start,
   output logic                conv_start,
   output logic                trial_step,
   output logic                last_trial
);
   import sar_pkg::*;

   sar_phase_t       phase_q;
   logic [ACQ_W-1:0] acq_cnt;
   logic [IDX_W-1:0] idx_q;
   logic             acq_ok;

   assign acq_ok = (acq_cnt >= ACQ_W'(MIN_ACQ));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= SQ_ACQ;
         acq_cnt <= '0;
         idx_q   <= '0;
      end else if (cs_n) begin
         phase_q <= SQ_ACQ;
         if (!acq_ok) acq_cnt <= acq_cnt + 1'b1;
      end else begin
         unique case (phase_q)
            SQ_ACQ: begin
               acq_cnt <= '0;
               idx_q   <= IDX_W'(N - 1);
               phase_q <= acq_ok ? SQ_TRIAL : SQ_HOLD;
            end
            SQ_TRIAL: begin
               if (idx_q == '0) phase_q <= SQ_HOLD;
               else             idx_q   <= idx_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign phase       = phase_q;
   assign bit_idx     = idx_q;
   assign frame_start = (phase_q == SQ_ACQ) && !cs_n;
   assign conv_start  = frame_start && acq_ok;
   assign trial_step  = (phase_q == SQ_TRIAL) && !cs_n;
   assign last_trial  = trial_step && (idx_q == '0);

endmodule

// File: rtl/sar_search.sv
`timescale 1ns/1ps
module sar_search #(
   parameter int N      = 12,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             conv_start,
   input  logic             trial_step,
   input  logic             last_trial,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             cmp_below,
   output logic [N-1:0]     code,
   output logic [N-1:0]     result
);
   localparam logic [N-1:0] MID_CODE = {1'b1, {(N-1){1'b0}}};
   localparam logic [N-1:0] ONE      = {{(N-1){1'b0}}, 1'b1};

   logic [N-1:0] code_q, result_q;
   logic [N-1:0] test_bit, decided, advanced;

   always_comb begin
      test_bit = ONE << bit_idx;
      decided  = cmp_below ? (code_q & ~test_bit) : code_q;
      advanced = decided | (test_bit >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          code_q <= '0;
      else if (cs_n)       code_q <= '0;
      else if (conv_start) code_q <= MID_CODE;
      else if (trial_step) code_q <= advanced;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          result_q <= '0;
      else if (last_trial) result_q <= decided;
   end

   assign code   = code_q;
   assign result = result_q;

endmodule

// File: rtl/sar_tx.sv
`timescale 1ns/1ps
module sar_tx #(
   parameter int N          = 12,
   parameter bit SIGNED_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n,
   input  logic         frame_start,
   input  logic [N-1:0] result_raw,
   output logic         sdo
);
   logic [N-1:0] word_fmt;
   logic [N-1:0] shreg;
   logic         live;
   logic         sdo_q;

   generate
      if (SIGNED_OUT) begin : g_twos
         assign word_fmt = {~result_raw[N-1], result_raw[N-2:0]};
      end else begin : g_plain
         assign word_fmt = result_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         live  <= 1'b0;
      end else if (cs_n) begin
         live  <= 1'b0;
      end else if (frame_start) begin
         shreg <= word_fmt;
         live  <= 1'b1;
      end else begin
         shreg <= {shreg[N-2:0], 1'b0};
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)    sdo_q <= 1'b0;
      else if (cs_n) sdo_q <= 1'b0;
      else           sdo_q <= live & shreg[N-1];
   end

   assign sdo = sdo_q & ~cs_n;

endmodule

// File: rtl/sar_sequencer.sv
`timescale 1ns/1ps
module sar_sequencer #(
   parameter int N          = 12,
   parameter int MIN_ACQ    = 2,
   parameter bit SIGNED_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n,
   input  logic         cmp_below,
   output logic         sample_en,
   output logic [N-1:0] dac_code,
   output logic         sdo
);
   import sar_pkg::*;

   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 2) begin : g_bad_width
         $error("sar_sequencer: N must be at least 2");
      end
      if (MIN_ACQ < 1) begin : g_bad_acq
         $error("sar_sequencer: MIN_ACQ must be at least 1");
      end
   endgenerate

   sar_phase_t       phase;
   logic [IDX_W-1:0] bit_idx;
   logic             frame_start, conv_start, trial_step, last_trial;
   logic [N-1:0]     result_q;

   sar_ctrl #(.N(N), .MIN_ACQ(MIN_ACQ)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .phase       (phase),
      .bit_idx     (bit_idx),
      .frame_start (frame_start),
      .conv_start  (conv_start),
      .trial_step  (trial_step),
      .last_trial  (last_trial)
   );

   sar_search #(.N(N)) u_search (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .conv_start (conv_start),
      .trial_step (trial_step),
      .last_trial (last_trial),
      .bit_idx    (bit_idx),
      .cmp_below  (cmp_below),
      .code       (dac_code),
      .result     (result_q)
   );

   sar_tx #(.N(N), .SIGNED_OUT(SIGNED_OUT)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .frame_start (frame_start),
      .result_raw  (result_q),
      .sdo         (sdo)
   );

   assign sample_en = (phase == SQ_ACQ);

endmodule

// File: rtl/sar_sequencer_chk.sv
`timescale 1ns/1ps
module sar_sequencer_chk #(
   parameter int N = 12
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cs_n,
   input logic         sample_en,
   input logic [N-1:0] dac_code,
   input logic         sdo,
   input logic [N-1:0] result_raw
);
   localparam logic [N-1:0] MID_CODE = {1'b1, {(N-1){1'b0}}};

   // R2: acquisition phase follows chip select high
   a_r2_sample_on: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> sample_en);

   // R2: acquisition ends on the edge that sees chip select low
   a_r2_sample_off: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !cs_n) |=> !sample_en);

   // R3: frame start yields mid-scale trial or no trial
   a_r3_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !cs_n) |=> (dac_code == MID_CODE || dac_code == '0));

   // R4: a decision clears at most one bit and sets at most one bit
   a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_en && !cs_n) |=> ($countones(dac_code ^ $past(dac_code)) <= 2));

   // R6: serial line idle while chip select is high
   a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sdo);

   // R8: stored result only moves after an edge inside a running frame
   a_r8_keep_result: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_raw) |-> $past(!cs_n && !sample_en));

   // R10: DAC parked at zero during acquisition
   a_r10_dac_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (dac_code == '0));

endmodule

bind sar_sequencer sar_sequencer_chk #(.N(N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .sample_en  (sample_en),
   .dac_code   (dac_code),
   .sdo        (sdo),
   .result_raw (result_q)
);

// File: tb/test_sar_sequencer.sv
`timescale 1ns/1ps
module test_sar_sequencer;
   localparam int N       = 12;
   localparam int MIN_ACQ = 2;

   logic         clk   = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n  = 1'b1;
   logic [N-1:0] ana   = '0;
   logic [N-1:0] dac_u, dac_s;
   logic         se_u, se_s, sdo_u, sdo_s;
   logic         cmp_u, cmp_s;

   assign cmp_u = (ana < dac_u);
   assign cmp_s = (ana < dac_s);

   always #2.5 clk = ~clk;

   sar_sequencer #(.N(N), .MIN_ACQ(MIN_ACQ), .SIGNED_OUT(1'b0)) i_sar_sequencer (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmp_below(cmp_u),
      .sample_en(se_u), .dac_code(dac_u), .sdo(sdo_u));

   sar_sequencer #(.N(N), .MIN_ACQ(MIN_ACQ), .SIGNED_OUT(1'b1)) i_sar_sequencer_s (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmp_below(cmp_s),
      .sample_en(se_s), .dac_code(dac_s), .sdo(sdo_s));

   int n_tests = 0;
   int n_fail  = 0;

   // behavioural reference model
   int           m_st;      // 0 acquire, 1 search, 2 wait
   int           m_acq;
   int           m_idx;
   logic [N-1:0] m_code, m_res;
   bit           m_live;
   bit           qu[$];
   bit           qs[$];
   bit           m_sdo_u, m_sdo_s;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_st = 0; m_acq = 0; m_idx = 0; m_code = '0; m_res = '0; m_live = 0;
      qu.delete(); qs.delete();
   endtask

   task automatic model_pos();
      if (cs_n) begin
         m_st = 0; m_code = '0; m_live = 0;
         if (m_acq < MIN_ACQ) m_acq++;
      end else if (m_st == 0) begin
         qu.delete(); qs.delete();
         for (int b = N - 1; b >= 0; b--) begin
            qu.push_back(m_res[b]);
            qs.push_back((b == N - 1) ? ~m_res[b] : m_res[b]);
         end
         m_live = 1;
         if (m_acq >= MIN_ACQ) begin
            m_code = '0; m_code[N-1] = 1'b1; m_idx = N - 1; m_st = 1;
         end else begin
            m_st = 2;
         end
         m_acq = 0;
      end else begin
         if (qu.size() > 0) begin void'(qu.pop_front()); void'(qs.pop_front()); end
         if (m_st == 1) begin
            if (ana < m_code) m_code[m_idx] = 1'b0;
            if (m_idx > 0) begin
               m_code[m_idx-1] = 1'b1;
               m_idx--;
            end else begin
               m_res = m_code;
               m_st  = 2;
            end
         end
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n || cs_n || !m_live) begin
         m_sdo_u = 0; m_sdo_s = 0;
      end else begin
         m_sdo_u = (qu.size() > 0) ? qu[0] : 1'b0;
         m_sdo_s = (qs.size() > 0) ? qs[0] : 1'b0;
      end
   end

   // one clock: update model at the edge, compare after it, return before the next drive point
   task automatic tick();
      @(posedge clk);
      if (!rst_n) model_reset(); else model_pos();
      #1;
      chk("R2 sample_en unsigned", se_u, (m_st == 0));
      chk("R2 sample_en signed",   se_s, (m_st == 0));
      chk("R4/R10 dac_code unsigned", dac_u, m_code);
      chk("R4/R10 dac_code signed",   dac_s, m_code);
      chk("R5/R6 sdo unsigned", sdo_u, m_sdo_u & ~cs_n);
      chk("R5/R6 sdo signed",   sdo_s, m_sdo_s & ~cs_n);
      #0.5;
   endtask

   logic [N-1:0] exp_prev = '0;

   task automatic frame(input logic [N-1:0] val, input int acq, input int low);
      logic [N-1:0] wu, ws;
      wu = '0; ws = '0;
      cs_n = 1'b1;
      ana  = val;
      for (int i = 0; i < acq; i++) tick();
      chk("R6 idle before frame", sdo_u, 0);
      cs_n = 1'b0;
      for (int i = 1; i <= low; i++) begin
         tick();
         if (i == 1) begin
            chk("R3 first trial", dac_u, (acq >= MIN_ACQ) ? 32'h800 : 32'h0);
            chk("R6 quiet before first falling edge", sdo_u, 0);
         end
         if (i >= 2 && i <= N + 1) begin
            wu = {wu[N-2:0], sdo_u};
            ws = {ws[N-2:0], sdo_s};
         end
      end
      if (low >= N + 1) begin
         chk("R5 word unsigned", wu, exp_prev);
         chk("R7 word signed", ws, {~exp_prev[N-1], exp_prev[N-2:0]});
         if (acq >= MIN_ACQ) begin
            chk("R4 final code", dac_u, val);
            exp_prev = val;
         end else begin
            chk("R9 no search after short acquisition", dac_u, 0);
         end
      end
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      m_sdo_u = 0; m_sdo_s = 0;
      #1.5;
      tick(); tick(); tick();
      chk("R1 reset sample_en", se_u, 1);
      chk("R1 reset dac_code", dac_u, 0);
      chk("R1 reset sdo", sdo_u, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 after reset dac_code", dac_u, 0);

      frame(12'h800, 3, 14);          // mid-scale input
      frame(12'h123, 2, 14);          // sends 0x800: signed word must be 0 (R7)
      frame(12'hFFF, 2, 14);
      frame(12'h000, 2, 14);
      frame(12'hA5A, 2, 15);
      frame(12'h5A5, 2, 13);          // complementary pattern, minimal low window
      // R8: chip select released after a few decisions
      frame(12'h3C3, 2, 6);
      frame(12'h111, 2, 14);
      chk("R8 abort kept previous result", exp_prev, 12'h111);
      // R9: acquisition too short
      frame(12'h777, 1, 14);
      frame(12'h222, 2, 14);          // still transmits 0x111
      frame(12'h000, 4, 14);          // transmits 0x222
      cs_n = 1'b1;
      tick(); tick();
      chk("R6 idle after last frame", sdo_s, 0);
      chk("R10 dac parked", dac_s, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule